// File: doc/BRIEF.md
# Slot Table Schedule Builder

This block computes the time-slot schedule used by a memory arbiter that shares one memory among up to 14 clients through a 64-entry slot table. Each client offers two inputs per region: a slot count for guaranteed bandwidth and an active flag that asks for a share of whatever slots remain. Two regions (external and internal memory) keep separate request counts, active flags and tables. A build is started for one region with a single-cycle start pulse.

A build runs in two passes. The placement pass walks the clients in ascending id and spreads each guaranteed client over the table at a fixed stride. The fill pass then walks the table in ascending slot order. It writes every entry to the table owner through a write port carrying region, slot index and client id. Empty entries are handed out round-robin among the active clients. A combinational admission check reports whether one more guaranteed request of a given size would still fit in a chosen region.

Top module: `slot_sched_builder`

## Requirements
- R1: While reset is held and after it is released, wr_en_o and done_o are low until a build is started.
- R2: Guaranteed clients are placed in ascending client id. For a client requesting R slots, the stride is 64/R (integer division) and the position starts at slot 0. At each step an occupied slot moves the position on by one. An empty slot is given to the client and the position moves on by the stride. The client is finished once the position reaches 64 or more.
- R3: A client whose request is zero places nothing. A request large enough that 64/R is zero (R above 64) is placed with a stride of one.
- R4: In the fill pass, each slot still empty gets the first active client at or after a rotating pointer (modulo 14). The pointer then moves to one past that client. The pointer starts at client 0 on every build.
- R5: If no client of the region is active, an empty slot gets the pointer's current value, and the pointer still moves on by one.
- R6: A build writes all 64 slots exactly once, in ascending slot order starting at 0, one write per cycle on consecutive cycles. Client ids are 4-bit values from 0 to 13.
- R7: done_o is high for exactly one cycle, in the cycle after the write of slot 63.
- R8: A start pulse that arrives while a build is running is ignored: the running build completes with its own region and results.
- R9: adm_ok_o is high exactly when the region's summed requests, plus its number of active clients, plus adm_req_i, plus one, is at most 64.
- R10: A build uses only the request counts and active flags of the region given with start. Every write of that build carries that region on wr_region_o. Region 0 occupies the low half of req_i and act_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a build |
| start_region_i | input | 1 | Region to build, sampled with start_i |
| req_i | input | 196 | Requested slot counts, 7 bits per client, region-major, client 0 lowest |
| act_i | input | 28 | Active flags, one per client, region-major |
| adm_region_i | input | 1 | Region for the admission check |
| adm_req_i | input | 7 | Size of the request under test |
| adm_ok_o | output | 1 | New request would fit |
| wr_en_o | output | 1 | Table write strobe |
| wr_region_o | output | 1 | Region of the write |
| wr_slot_o | output | 6 | Slot index of the write |
| wr_client_o | output | 4 | Client id written |
| done_o | output | 1 | Build complete pulse |

## Verification
The assertions assume that the request counts and active flags of the region being built stay stable from start to done. They also assume that start_region_i names an existing region. The bench changes its configuration only between builds, while the builder is idle, and it uses only the two valid region values. It checks each written entry against a model of the two passes computed in the bench. The admission check is swept over request sizes from 0 to 70 for several region loads.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PLACE = 2'd1,
        PH_FILL  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/sched_stride.sv
module sched_stride #(
    parameter int NUM_SLOTS = 64,
    parameter int CNT_W     = 7,
    parameter int POS_W     = 7
) (
    input  logic [CNT_W-1:0] req_i,
    output logic [POS_W-1:0] stride_o
);
    logic [POS_W-1:0] quo;

    always_comb begin
        if (req_i == '0) begin
            quo = '0;
        end else begin
            quo = POS_W'(NUM_SLOTS / int'(req_i));
        end
        stride_o = (quo == '0) ? POS_W'(1) : quo;
    end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int NUM_CLIENTS = 14,
    parameter int CID_W       = 4
) (
    input  logic [NUM_CLIENTS-1:0] act_i,
    input  logic [CID_W-1:0]       ptr_i,
    output logic [CID_W-1:0]       pick_o,
    output logic [CID_W-1:0]       next_ptr_o
);
    logic found;
    int   idx;

    always_comb begin
        pick_o = ptr_i;
        found  = 1'b0;
        idx    = 0;
        for (int k = 0; k < NUM_CLIENTS; k++) begin
            idx = (int'(ptr_i) + k) % NUM_CLIENTS;
            if (!found && act_i[idx]) begin
                pick_o = CID_W'(idx);
                found  = 1'b1;
            end
        end
        next_ptr_o = (pick_o == CID_W'(NUM_CLIENTS - 1)) ? '0 : pick_o + 1'b1;
    end
endmodule

// File: rtl/sched_admit.sv
module sched_admit #(
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_SLOTS   = 64,
    parameter int CNT_W       = 7
) (
    input  logic [NUM_CLIENTS*CNT_W-1:0] req_i,
    input  logic [NUM_CLIENTS-1:0]       act_i,
    input  logic [CNT_W-1:0]             new_req_i,
    output logic                         ok_o
);
    localparam int SUM_W = CNT_W + $clog2(NUM_CLIENTS + 2) + 1;

    logic [SUM_W-1:0] total;

    always_comb begin
        total = SUM_W'(new_req_i) + SUM_W'(1);
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            total = total + SUM_W'(req_i[c*CNT_W +: CNT_W]) + SUM_W'(act_i[c]);
        end
        ok_o = (total <= SUM_W'(NUM_SLOTS));
    end
endmodule

// File: rtl/slot_sched_builder.sv
module slot_sched_builder
    import slot_sched_pkg::*;
#(
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_REGIONS = 2,
    parameter int CNT_W       = 7,
    localparam int CID_W      = $clog2(NUM_CLIENTS + 2),
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int RGN_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start_i,
    input  logic [RGN_W-1:0]                         start_region_i,
    input  logic [NUM_REGIONS*NUM_CLIENTS*CNT_W-1:0] req_i,
    input  logic [NUM_REGIONS*NUM_CLIENTS-1:0]       act_i,
    input  logic [RGN_W-1:0]                         adm_region_i,
    input  logic [CNT_W-1:0]                         adm_req_i,
    output logic                                     adm_ok_o,
    output logic                                     wr_en_o,
    output logic [RGN_W-1:0]                         wr_region_o,
    output logic [SLOT_W-1:0]                        wr_slot_o,
    output logic [CID_W-1:0]                         wr_client_o,
    output logic                                     done_o
);
    localparam int POS_W = SLOT_W + 1;
    localparam int RQ_W  = NUM_CLIENTS * CNT_W;
    localparam logic [CID_W-1:0] EMPTY_ID = CID_W'(NUM_CLIENTS + 1);

    typedef struct packed {
        phase_e                              phase;
        logic [RGN_W-1:0]                    rgn;
        logic [CID_W-1:0]                    cli;
        logic [POS_W-1:0]                    pos;
        logic [CID_W-1:0]                    ptr;
        logic [NUM_SLOTS-1:0]                occ;
        logic [NUM_SLOTS-1:0][CID_W-1:0]     tab;
        logic                                wr_en;
        logic [RGN_W-1:0]                    wr_rgn;
        logic [SLOT_W-1:0]                   wr_slot;
        logic [CID_W-1:0]                    wr_cli;
        logic                                done;
    } state_t;

    state_t st_d, st_q;

    logic [RQ_W-1:0]        bld_req;
    logic [NUM_CLIENTS-1:0] bld_act;
    logic [CNT_W-1:0]       cur_req;
    logic [POS_W-1:0]       stride;
    logic [CID_W-1:0]       pick, next_ptr;
    logic [SLOT_W-1:0]      cur_slot;

    assign bld_req  = req_i[int'(st_q.rgn)*RQ_W +: RQ_W];
    assign bld_act  = act_i[int'(st_q.rgn)*NUM_CLIENTS +: NUM_CLIENTS];
    assign cur_req  = bld_req[int'(st_q.cli)*CNT_W +: CNT_W];
    assign cur_slot = st_q.pos[SLOT_W-1:0];

    sched_stride #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W),
        .POS_W     (POS_W)
    ) stride_i (
        .req_i    (cur_req),
        .stride_o (stride)
    );

    sched_rr_pick #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .CID_W       (CID_W)
    ) pick_i (
        .act_i      (bld_act),
        .ptr_i      (st_q.ptr),
        .pick_o     (pick),
        .next_ptr_o (next_ptr)
    );

    sched_admit #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .NUM_SLOTS   (NUM_SLOTS),
        .CNT_W       (CNT_W)
    ) admit_i (
        .req_i     (req_i[int'(adm_region_i)*RQ_W +: RQ_W]),
        .act_i     (act_i[int'(adm_region_i)*NUM_CLIENTS +: NUM_CLIENTS]),
        .new_req_i (adm_req_i),
        .ok_o      (adm_ok_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_PLACE;
                    st_d.rgn   = start_region_i;
                    st_d.cli   = '0;
                    st_d.pos   = '0;
                    st_d.occ   = '0;
                    for (int s = 0; s < NUM_SLOTS; s++) begin
                        st_d.tab[s] = EMPTY_ID;
                    end
                end
            end
            PH_PLACE: begin
                if (cur_req == '0 || st_q.pos >= POS_W'(NUM_SLOTS)) begin
                    st_d.pos = '0;
                    if (st_q.cli == CID_W'(NUM_CLIENTS - 1)) begin
                        st_d.phase = PH_FILL;
                        st_d.ptr   = '0;
                    end else begin
                        st_d.cli = st_q.cli + 1'b1;
                    end
                end else if (st_q.occ[cur_slot]) begin
                    st_d.pos = st_q.pos + 1'b1;
                end else begin
                    st_d.occ[cur_slot] = 1'b1;
                    st_d.tab[cur_slot] = st_q.cli;
                    st_d.pos           = st_q.pos + stride;
                end
            end
            PH_FILL: begin
                st_d.wr_en   = 1'b1;
                st_d.wr_rgn  = st_q.rgn;
                st_d.wr_slot = cur_slot;
                if (st_q.occ[cur_slot]) begin
                    st_d.wr_cli = st_q.tab[cur_slot];
                end else begin
                    st_d.wr_cli        = pick;
                    st_d.tab[cur_slot] = pick;
                    st_d.ptr           = next_ptr;
                end
                if (cur_slot == SLOT_W'(NUM_SLOTS - 1)) begin
                    st_d.phase = PH_DONE;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
            default: begin
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o     = st_q.wr_en;
    assign wr_region_o = st_q.wr_rgn;
    assign wr_slot_o   = st_q.wr_slot;
    assign wr_client_o = st_q.wr_cli;
    assign done_o      = st_q.done;

    assert_first_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> wr_slot_o == '0);

    assert_slot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_slot_o != '0) |->
            ($past(wr_en_o) && wr_slot_o == SLOT_W'($past(wr_slot_o) + 1'b1)));

    assert_client_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_client_o < CID_W'(NUM_CLIENTS));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && $past(wr_slot_o) == SLOT_W'(NUM_SLOTS - 1) && !wr_en_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_region_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> wr_region_o == $past(wr_region_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && st_q.phase != PH_DONE) |=> $stable(st_q.rgn));
endmodule

// File: tb/slot_sched_builder_tb.sv
module slot_sched_builder_tb_top;
    localparam int NC = 14;
    localparam int NS = 64;
    localparam int NR = 2;
    localparam int CW = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [0:0]        start_region_i = '0;
    logic [NR*NC*CW-1:0] req_i = '0;
    logic [NR*NC-1:0]  act_i = '0;
    logic [0:0]        adm_region_i = '0;
    logic [CW-1:0]     adm_req_i = '0;
    logic              adm_ok_o;
    logic              wr_en_o;
    logic [0:0]        wr_region_o;
    logic [5:0]        wr_slot_o;
    logic [3:0]        wr_client_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;
    int b_req [NR][NC];
    bit b_act [NR][NC];
    int exp_tab [NS];

    always #2ns clk = ~clk;

    slot_sched_builder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .start_region_i (start_region_i),
        .req_i          (req_i),
        .act_i          (act_i),
        .adm_region_i   (adm_region_i),
        .adm_req_i      (adm_req_i),
        .adm_ok_o       (adm_ok_o),
        .wr_en_o        (wr_en_o),
        .wr_region_o    (wr_region_o),
        .wr_slot_o      (wr_slot_o),
        .wr_client_o    (wr_client_o),
        .done_o         (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_cfg();
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                b_req[r][c] = 0;
                b_act[r][c] = 1'b0;
            end
    endtask

    task automatic apply_cfg();
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                req_i[(r*NC+c)*CW +: CW] = CW'(b_req[r][c]);
                act_i[r*NC+c] = b_act[r][c];
            end
    endtask

    task automatic model(input int rg);
        int ptr;
        for (int s = 0; s < NS; s++) exp_tab[s] = NC + 1;
        for (int c = 0; c < NC; c++) begin
            int st;
            int pos;
            if (b_req[rg][c] == 0) continue;
            st = NS / b_req[rg][c];
            if (st == 0) st = 1;
            pos = 0;
            while (pos < NS) begin
                if (exp_tab[pos] != NC + 1) pos++;
                else begin
                    exp_tab[pos] = c;
                    pos += st;
                end
            end
        end
        ptr = 0;
        for (int s = 0; s < NS; s++) begin
            if (exp_tab[s] == NC + 1) begin
                int cl;
                bit found;
                cl = ptr;
                found = 1'b0;
                for (int k = 0; k < NC; k++) begin
                    int idx;
                    idx = (ptr + k) % NC;
                    if (!found && b_act[rg][idx]) begin
                        cl = idx;
                        found = 1'b1;
                    end
                end
                exp_tab[s] = cl;
                ptr = (cl + 1) % NC;
            end
        end
    endtask

    task automatic run_build(input int rg, input bit poke, input string tag);
        int nwr;
        int last_wr;
        bit done_seen;
        int cyc;
        model(rg);
        @(negedge clk);
        start_i = 1'b1;
        start_region_i = 1'(rg);
        @(negedge clk);
        start_i = 1'b0;
        nwr = 0;
        last_wr = -10;
        done_seen = 1'b0;
        cyc = 0;
        while (!done_seen && cyc < 3000) begin
            if (wr_en_o) begin
                check(int'(wr_slot_o) == nwr, "R6 slot order", int'(wr_slot_o), nwr);
                check(int'(wr_region_o) == rg, "R10 write region", int'(wr_region_o), rg);
                if (nwr < NS)
                    check(int'(wr_client_o) == exp_tab[nwr], tag, int'(wr_client_o), exp_tab[nwr]);
                nwr++;
                last_wr = cyc;
            end
            if (done_o) begin
                done_seen = 1'b1;
                check(nwr == NS, "R6 write count", nwr, NS);
                check(last_wr == cyc - 1 && !wr_en_o, "R7 done timing", cyc - last_wr, 1);
            end
            if (poke) begin
                start_i = (cyc == 4 || cyc == 120) ? 1'b1 : 1'b0;
                start_region_i = 1'(1 - rg);
            end
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(done_seen, "R7 done seen", int'(done_seen), 1);
        check(!done_o && !wr_en_o, "R7 done single cycle", int'(done_o), 0);
    endtask

    task automatic adm_sweep(input int rg);
        int base;
        base = 1;
        for (int c = 0; c < NC; c++) base += b_req[rg][c] + int'(b_act[rg][c]);
        adm_region_i = 1'(rg);
        for (int n = 0; n <= 70; n++) begin
            adm_req_i = CW'(n);
            #1ns;
            check(adm_ok_o == ((base + n) <= NS), "R9 admission", int'(adm_ok_o), int'((base + n) <= NS));
        end
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_cfg();
        apply_cfg();
        repeat (3) @(negedge clk);
        check(!wr_en_o && !done_o, "R1 reset outputs", int'(wr_en_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!wr_en_o && !done_o, "R1 idle after reset", int'(done_o), 0);

        // R4: two active clients share all slots alternately
        b_act[0][10] = 1'b1;
        b_act[0][11] = 1'b1;
        apply_cfg();
        run_build(0, 1'b0, "R4 fill alternation");
        adm_sweep(0);

        // R2: colliding guaranteed clients with gaps filled by active ones
        clear_cfg();
        b_req[0][0] = 4;
        b_req[0][3] = 8;
        b_req[0][5] = 3;
        b_req[0][9] = 5;
        b_act[0][2] = 1'b1;
        b_act[0][7] = 1'b1;
        b_act[0][13] = 1'b1;
        apply_cfg();
        run_build(0, 1'b0, "R2 placement");
        adm_sweep(0);

        // R5: no active client in region 1
        clear_cfg();
        b_req[1][1] = 2;
        b_req[1][6] = 7;
        apply_cfg();
        run_build(1, 1'b0, "R5 no active");
        adm_sweep(1);

        // R3: oversize request takes stride one, zero request skipped
        clear_cfg();
        b_req[1][2] = 100;
        b_req[1][4] = 0;
        b_act[1][4] = 1'b1;
        apply_cfg();
        run_build(1, 1'b0, "R3 oversize stride");

        // R3: single slot request and a full 64 request
        clear_cfg();
        b_req[0][12] = 1;
        b_req[0][13] = 64;
        b_act[0][0] = 1'b1;
        apply_cfg();
        run_build(0, 1'b0, "R3 single and full");

        // R8 and R10: distinct configs per region, start pulses mid-build
        clear_cfg();
        b_req[0][1] = 16;
        b_act[0][3] = 1'b1;
        b_act[0][8] = 1'b1;
        b_req[1][0] = 32;
        b_req[1][9] = 6;
        b_act[1][5] = 1'b1;
        apply_cfg();
        run_build(0, 1'b1, "R8 start ignored");
        run_build(1, 1'b1, "R10 region select");
        adm_sweep(0);
        adm_sweep(1);

        // R4: pointer restarts at client 0 on a repeated build
        run_build(1, 1'b0, "R4 pointer restart");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule